// File: doc/BRIEF.md
# Event FIFO Interrupt Controller

This block holds change-of-state event records in a first-in first-out queue until a host processor drains them. While it does so, it watches three conditions: the queue grows past a programmable fill level, a queued record waits longer than a programmable service time, or a record arrives at a full queue. Each condition sets a sticky status bit. Every status bit has a mask bit. The status bits left unmasked are combined into one registered interrupt line.

The host reads the status and mask words through a small register port with one address bit. It clears status bits in one of two ways. With clear-on-read selected, a read of the status word clears it. Otherwise the host writes ones to the status bits it wants cleared. An overflow discards the whole queue, together with the record that caused it, so the host resynchronises from a clean state.

Top module: `evt_fifo_irq`

## Requirements
- R1: Records pop out in the order they were written. `fifo_count` gives the number held and `rd_data` shows the oldest record. A pop when the queue is empty is ignored.
- R2: A write while the queue holds DEPTH records and no pop is requested is an overflow. At the next edge the queue is empty, the written record is dropped, and status bit 0 is set.
- R3: A write and a pop in the same cycle on a full queue are both accepted. The count stays at DEPTH and no overflow is flagged.
- R4: Status bit 2 sets one edge after a cycle in which `fifo_count` is greater than `cfg_depth_thr`.
- R5: The service timer holds at 0 while the queue is empty. It restarts at 0 on every accepted pop and otherwise counts one step per cycle. If it reaches `cfg_timer_lim` while records are queued and no pop is accepted, status bit 1 sets and the timer restarts.
- R6: Status bits are sticky. Address 0 reads the status word and address 1 reads the mask word. In both words, bit 2 is depth, bit 1 is timer and bit 0 is overflow, and bits 15:3 read as 0. A write to address 1 loads the mask from bits 2:0.
- R7: With `cfg_cor` = 1, a read of address 0 returns the current status and clears all status bits at that edge. A write to address 0 has no effect.
- R8: With `cfg_cor` = 0, a write to address 0 clears each status bit whose data bit is 1. A read does not clear anything.
- R9: When a status bit is set and cleared in the same cycle, the set wins.
- R10: After reset the status bits are 0, the mask bits are all 1, `irq` is 0 and the queue is empty.
- R11: `irq` is 1 exactly one edge after a cycle in which some status bit is 1 and its mask bit is 0. A mask bit of 1 blocks its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Push a record |
| wr_data | input | WIDTH | Record to push |
| pop | input | 1 | Remove the oldest record |
| rd_data | output | WIDTH | Oldest record |
| fifo_count | output | CW | Number of records held |
| fifo_empty | output | 1 | Queue holds no record |
| cfg_depth_thr | input | CW | Fill level that must be exceeded to set the depth status bit |
| cfg_timer_lim | input | TW | Service timer limit in cycles |
| cfg_cor | input | 1 | 1 selects clear-on-read, 0 selects write-one-to-clear |
| reg_addr | input | 1 | 0 selects the status word, 1 selects the mask word |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
If the read or write pointers go wrong, `rd_data` shows the wrong record on the very next pop. A stale count shows up at `fifo_count` in the same cycle, and it moves the depth and overflow bits one edge later. If the timer is not restarted, status bit 1 sets too early, within `cfg_timer_lim` cycles of the missed pop. A wrong clear or mask decision appears in `reg_rdata` one edge later and on `irq` the edge after that. A behavioural model compares every one of these outputs on every cycle, so the first wrong cycle is reported.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned NUM_SRC   = 3;
  localparam int unsigned BIT_OVF   = 0;
  localparam int unsigned BIT_TMR   = 1;
  localparam int unsigned BIT_DEPTH = 2;

  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_sel_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             pop_acc,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    count_d;
  logic             full, wr_acc;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign pop_acc = pop && (count != '0);
  assign ovf     = wr_valid && full && !pop;
  assign wr_acc  = wr_valid && (!full || pop);
  assign rd_data = mem[rptr_q];

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    count_d = count;
    if (ovf) begin
      wptr_d  = '0;
      rptr_d  = '0;
      count_d = '0;
    end else begin
      if (wr_acc)  wptr_d = ptr_inc(wptr_q);
      if (pop_acc) rptr_d = ptr_inc(rptr_q);
      case ({wr_acc, pop_acc})
        2'b10:   count_d = count + CW'(1);
        2'b01:   count_d = count - CW'(1);
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      count  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr_q] <= wr_data;
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_empty_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !wr_valid) |=> count == '0);
  p_flush_on_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == '0);
  p_full_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && pop) |=> count == CW'(DEPTH));
endmodule

// File: rtl/svc_timer.sv
module svc_timer #(
  parameter int unsigned CW = 6,
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          pop_acc,
  input  logic [TW-1:0] lim,
  output logic          expire
);
  logic [TW-1:0] tmr_q, tmr_d;
  logic          idle, at_lim;

  assign idle   = (count == '0);
  assign at_lim = (tmr_q == lim);
  assign expire = !idle && !pop_acc && at_lim;

  always_comb begin
    if (idle || pop_acc || at_lim) tmr_d = '0;
    else                           tmr_d = tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  p_tmr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> tmr_q == '0);
  p_tmr_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |=> tmr_q == '0);
endmodule

// File: rtl/irq_status.sv
module irq_status
  import evt_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         set_i,
  input  logic             cfg_cor,
  input  logic             reg_addr,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output src_vec_t         status_q,
  output logic             irq
);
  src_vec_t status_d, mask_q, mask_d, clr;
  logic     irq_d, sel_status, sel_mask;
  logic     unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:NUM_SRC];
  assign sel_status   = (reg_sel_e'(reg_addr) == REG_STATUS);
  assign sel_mask     = (reg_sel_e'(reg_addr) == REG_MASK);

  always_comb begin
    clr = '0;
    if (cfg_cor) begin
      if (reg_rd && sel_status) clr = '1;
    end else begin
      if (reg_wr && sel_status) clr = reg_wdata[NUM_SRC-1:0];
    end
    status_d = (status_q & ~clr) | set_i;
    mask_d   = (reg_wr && sel_mask) ? reg_wdata[NUM_SRC-1:0] : mask_q;
    irq_d    = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
      irq      <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq      <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_mask) reg_rdata[NUM_SRC-1:0] = mask_q;
    else          reg_rdata[NUM_SRC-1:0] = status_q;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));
  p_irq_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & ~mask_q)) |=> irq);
  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_q & ~mask_q)) |=> !irq);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd && !reg_wr) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/evt_fifo_irq.sv
module evt_fifo_irq
  import evt_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned TW    = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    fifo_count,
  output logic             fifo_empty,
  input  logic [CW-1:0]    cfg_depth_thr,
  input  logic [TW-1:0]    cfg_timer_lim,
  input  logic             cfg_cor,
  input  logic             reg_addr,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             irq
);
  logic     pop_acc, ovf, tmr_exp;
  src_vec_t set_vec, status;

  evt_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .pop(pop), .rd_data(rd_data), .count(fifo_count),
    .pop_acc(pop_acc), .ovf(ovf)
  );

  svc_timer #(.CW(CW), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .count(fifo_count), .pop_acc(pop_acc),
    .lim(cfg_timer_lim), .expire(tmr_exp)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_OVF]   = ovf;
    set_vec[BIT_TMR]   = tmr_exp;
    set_vec[BIT_DEPTH] = (fifo_count > cfg_depth_thr);
  end

  irq_status u_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .cfg_cor(cfg_cor),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_q(status),
    .irq(irq)
  );

  assign fifo_empty = (fifo_count == '0);

  p_ovf_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> status[BIT_OVF]);
  p_depth_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count > cfg_depth_thr) |=> status[BIT_DEPTH]);
endmodule

// File: tb/test_evt_fifo_irq.sv
`timescale 1ns/1ps
module test_evt_fifo_irq;
  localparam int DEPTH = 32;
  localparam int WIDTH = 16;
  localparam int TW    = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_valid, pop, cfg_cor, reg_addr, reg_rd, reg_wr;
  logic [WIDTH-1:0] wr_data, rd_data;
  logic [CW-1:0]    fifo_count, cfg_depth_thr;
  logic             fifo_empty, irq;
  logic [TW-1:0]    cfg_timer_lim;
  logic [15:0]      reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  evt_fifo_irq #(.DEPTH(DEPTH), .WIDTH(WIDTH), .TW(TW)) i_evt_fifo_irq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .pop(pop), .rd_data(rd_data), .fifo_count(fifo_count),
    .fifo_empty(fifo_empty), .cfg_depth_thr(cfg_depth_thr),
    .cfg_timer_lim(cfg_timer_lim), .cfg_cor(cfg_cor), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Behavioural reference model
  logic [WIDTH-1:0] q[$];
  logic [2:0]       m_stat, m_mask;
  logic             m_irq;
  int               m_tmr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_stat = 3'b000;
      m_mask = 3'b111;
      m_irq  = 1'b0;
      m_tmr  = 0;
    end else begin
      int cnt;
      bit full, popa, ovf, exp, dep;
      logic [2:0] clr;
      cnt  = q.size();
      full = (cnt == DEPTH);
      popa = pop && (cnt != 0);
      ovf  = wr_valid && full && !pop;
      exp  = (cnt != 0) && !popa && (m_tmr == int'(cfg_timer_lim));
      dep  = cnt > int'(cfg_depth_thr);
      if (cnt == 0 || popa || m_tmr == int'(cfg_timer_lim)) m_tmr = 0;
      else m_tmr = m_tmr + 1;
      m_irq = |(m_stat & ~m_mask);
      clr = 3'b000;
      if (cfg_cor && reg_rd && !reg_addr) clr = 3'b111;
      else if (!cfg_cor && reg_wr && !reg_addr) clr = reg_wdata[2:0];
      m_stat = (m_stat & ~clr) | {dep, exp, ovf};
      if (reg_wr && reg_addr) m_mask = reg_wdata[2:0];
      if (ovf) q.delete();
      else begin
        if (popa) void'(q.pop_front());
        if (wr_valid) q.push_back(wr_data);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    wr_valid = 1'b0; pop = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
    reg_addr = 1'b0; reg_wdata = '0; wr_data = '0;
  endtask

  // Advance one cycle, compare against the model, return inputs to idle
  task automatic cyc();
    @(negedge clk);
    chk(irq, m_irq, "R11 irq");
    chk(fifo_count, q.size(), "R1 count");
    chk(fifo_empty, q.size() == 0, "R1 empty");
    if (q.size() > 0) chk(rd_data, q[0], "R1 head");
    chk(reg_rdata, reg_addr ? {13'b0, m_mask} : {13'b0, m_stat}, "R6 rdata");
    set_idle();
  endtask

  task automatic peek(input logic a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
    reg_addr = 1'b0;
  endtask

  task automatic push(input logic [WIDTH-1:0] d);
    wr_valid = 1'b1; wr_data = d; cyc();
  endtask

  task automatic do_pop();
    pop = 1'b1; cyc();
  endtask

  task automatic reg_write(input logic a, input logic [15:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d; cyc();
  endtask

  task automatic reg_read0();
    reg_addr = 1'b0; reg_rd = 1'b1; cyc();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    set_idle();
    cfg_depth_thr = CW'(4);
    cfg_timer_lim = TW'(200);
    cfg_cor = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    peek(1'b0, v); chk(v, 16'h0000, "R10 status");
    peek(1'b1, v); chk(v, 16'h0007, "R10 mask");
    chk(irq, 0, "R10 irq");
    chk(fifo_count, 0, "R10 count");
    cyc();

    // Unmask all, fill past the threshold
    reg_write(1'b1, 16'h0000);
    for (int i = 0; i < 5; i++) push(16'hA000 + 16'(i));
    cyc(); cyc();
    peek(1'b0, v); chk(v[2], 1, "R4 depth bit");
    chk(irq, 1, "R11 irq unmasked");
    reg_write(1'b0, 16'h0004);
    peek(1'b0, v); chk(v[2], 1, "R9 set beats clear");
    do_pop(); do_pop(); cyc();
    reg_write(1'b0, 16'h0004); cyc();
    peek(1'b0, v); chk(v[2], 0, "R8 w1c clears");
    cyc();
    chk(irq, 0, "R11 irq drops");
    chk(rd_data, 16'hA002, "R1 order");
    do_pop(); do_pop(); do_pop();
    do_pop();
    chk(fifo_count, 0, "R1 pop empty ignored");

    // Service timer
    cfg_timer_lim = TW'(10);
    push(16'h1111); push(16'h2222);
    repeat (8) cyc();
    do_pop();
    repeat (8) cyc();
    peek(1'b0, v); chk(v[1], 0, "R5 restart on pop");
    repeat (5) cyc();
    peek(1'b0, v); chk(v[1], 1, "R5 timer bit");
    reg_read0();
    peek(1'b0, v); chk(v[1], 1, "R8 read keeps");
    do_pop();
    reg_write(1'b0, 16'h0007); cyc();
    peek(1'b0, v); chk(v, 16'h0000, "R8 all cleared");

    // Overflow and full swap
    cfg_depth_thr = CW'(40);
    for (int i = 0; i < DEPTH; i++) push(16'hB000 + 16'(i));
    chk(fifo_count, DEPTH, "R1 full count");
    wr_valid = 1'b1; wr_data = 16'hBEEF; pop = 1'b1; cyc();
    chk(fifo_count, DEPTH, "R3 count kept");
    peek(1'b0, v); chk(v[0], 0, "R3 no overflow");
    push(16'hC000);
    chk(fifo_count, 0, "R2 flushed");
    peek(1'b0, v); chk(v[0], 1, "R2 ovf bit");
    push(16'hC001);
    chk(rd_data, 16'hC001, "R2 dropped record");
    do_pop(); cyc();

    // Clear-on-read
    cfg_cor = 1'b1;
    reg_read0(); cyc();
    peek(1'b0, v); chk(v, 16'h0000, "R7 read clears");
    push(16'hD000);
    repeat (12) cyc();
    do_pop();
    reg_write(1'b0, 16'h0007); cyc();
    peek(1'b0, v); chk(v[1], 1, "R7 write ignored");
    reg_read0();
    peek(1'b0, v); chk(v, 16'h0000, "R7 cleared again");

    // Masking
    reg_write(1'b1, 16'h0007);
    push(16'hE000);
    repeat (12) cyc();
    peek(1'b0, v); chk(v[1], 1, "R5 timer set");
    chk(irq, 0, "R11 masked");
    reg_write(1'b1, 16'h0005); cyc();
    chk(irq, 1, "R11 unmasked timer");
    peek(1'b0, v); chk(v[15:3], 0, "R6 upper zero");
    peek(1'b1, v); chk(v, 16'h0005, "R6 mask readback");
    do_pop(); cyc();

    finish_run();
  end
endmodule